// File: doc/BRIEF.md
# Prefix Register Select Decoder

This block keeps the operand-select state of a 16-bit processor whose instructions carry no register fields of their own. One-byte prefix opcodes issued ahead of an instruction choose its source register, its destination register and an alternate meaning for its opcode. The block decodes each accepted opcode byte, updates that prefix state, and presents the current source index, destination index and alternate-mode bits to the rest of the core.

Two further jobs sit here because they depend only on the prefix state. A destination prefix issued while the "paired" flag is set becomes a register-to-register move: the block raises a write strobe carrying the source register's read data. That write goes into the chosen index, and when the target is the program counter (r15) the normal program-counter increment is suppressed. For the pointer-addressed store and load opcodes, the block also works out the access: store or load, byte or word, which pointer register to read, and the two byte addresses of a word.

The prefix state is a small state machine. Its mode states are PLAIN (no alternate mode), ALT1, ALT2 and ALT3 (both). Each mode also carries the paired flag and the two indices. The transitions are: SET-ALT1, SET-ALT2 and SET-ALT3, which OR bits into the mode; SELECT-PAIR (0x2n); SELECT-DEST (0x1n with the flag clear); MOVE (0x1n with the flag set), which returns to PLAIN; COMPLETE (any other opcode), which returns to PLAIN; and HOLD (no opcode offered).

Top module: `pfx_select_decoder`

## Requirements
- R1: After reset the mode is PLAIN (alt1 = 0, alt2 = 0), the paired flag is 0 and both indices are 0. Until an opcode is accepted, no write strobe and no memory request is raised.
- R2: An accepted opcode 0x20+n (n = low nibble) sets the paired flag and makes n both the source and the destination index from the next cycle on. The mode bits are left unchanged.
- R3: An accepted opcode 0x10+n with the paired flag clear makes n the destination index. The source index, the flag and the mode bits are left unchanged, and no write strobe is raised.
- R4: An accepted opcode 0x10+n with the paired flag set raises wr_en in the same cycle, with wr_idx = n and wr_data = src_rdata. From the next cycle on the mode is PLAIN, the flag is 0 and both indices are 0.
- R5: An accepted 0x3D ORs the alt1 bit into the mode, 0x3E ORs the alt2 bit and 0x3F ORs both. Each of the three clears the paired flag and leaves both indices unchanged, so prefixes chain.
- R6: Any other accepted opcode (every value outside 0x10-0x2F and 0x3D-0x3F) completes an instruction. From the next cycle on the mode is PLAIN, the flag is 0 and both indices are 0.
- R7: Opcodes 0x30-0x3B are stores and 0x40-0x4B are loads, with ptr_idx = low nibble. For these, mem_req = 1, mem_we = 1 for stores only, and mem_byte equals the current alt1 bit (set in ALT1 and ALT3). Opcodes 0x3C and 0x4C raise no mem_req.
- R8: During a memory access addr_lo = ptr_rdata and addr_hi = ptr_rdata with bit 0 inverted. The low byte of a word goes to addr_lo and the high byte to addr_hi.
- R9: pc_step is 1 for every accepted opcode except a MOVE into r15, for which it is 0. It is 0 when no opcode is offered.
- R10: With op_valid low, the prefix state holds and wr_en, mem_req and pc_step stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An opcode byte is offered and taken this cycle |
| op_byte | input | 8 | Opcode byte |
| src_rdata | input | 16 | Register file read data at src_idx |
| ptr_rdata | input | 16 | Register file read data at ptr_idx |
| src_idx | output | 4 | Current source register index |
| dst_idx | output | 4 | Current destination register index |
| alt1 | output | 1 | Alternate mode bit 1 |
| alt2 | output | 1 | Alternate mode bit 2 |
| b_flag | output | 1 | Paired flag (source and destination set together) |
| wr_en | output | 1 | Register write strobe for MOVE |
| wr_idx | output | 4 | Register index written by MOVE |
| wr_data | output | 16 | Data written by MOVE |
| pc_step | output | 1 | Apply the normal program-counter increment |
| mem_req | output | 1 | Pointer-addressed memory access this cycle |
| mem_we | output | 1 | Access is a store |
| mem_byte | output | 1 | Access is one byte rather than a word |
| ptr_idx | output | 4 | Pointer register index (r0-r11) |
| addr_lo | output | 16 | Address of the low byte |
| addr_hi | output | 16 | Address of the high byte (bit 0 inverted) |

## Verification
The assertions assume that op_valid and op_byte are stable around the clock edge. They also assume that src_rdata and ptr_rdata are combinational reads of the register file at src_idx and ptr_idx, so that the MOVE and address checks can relate the inputs to the outputs within one cycle. The bench drives every input on the falling edge and holds it through the rising edge. It supplies read data that stands in for the addressed register, and it returns op_valid to 0 between opcodes so that each transition can be checked on its own before the next opcode arrives.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    typedef enum logic [1:0] {
        MD_PLAIN = 2'b00,
        MD_ALT1  = 2'b01,
        MD_ALT2  = 2'b10,
        MD_ALT3  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        OC_OTHER,
        OC_TO,
        OC_WITH,
        OC_SETA1,
        OC_SETA2,
        OC_SETA3,
        OC_STORE,
        OC_LOAD
    } opcls_e;

    localparam int unsigned PTR_LAST = 11;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [7:0] op_byte,
    output opcls_e     cls
);
    logic [3:0] lo_nib;
    assign lo_nib = op_byte[3:0];

    always_comb begin
        cls = OC_OTHER;
        unique case (op_byte[7:4])
            4'h1: cls = OC_TO;
            4'h2: cls = OC_WITH;
            4'h3: begin
                if (32'(lo_nib) <= PTR_LAST)  cls = OC_STORE;
                else if (lo_nib == 4'hD)      cls = OC_SETA1;
                else if (lo_nib == 4'hE)      cls = OC_SETA2;
                else if (lo_nib == 4'hF)      cls = OC_SETA3;
                else                          cls = OC_OTHER;
            end
            4'h4: cls = (32'(lo_nib) <= PTR_LAST) ? OC_LOAD : OC_OTHER;
            default: cls = OC_OTHER;
        endcase
    end
endmodule

// File: rtl/pfx_state.sv
module pfx_state
    import pfx_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  opcls_e           cls,
    input  logic [IDX_W-1:0] op_idx,
    output mode_e            mode_q,
    output logic             b_q,
    output logic [IDX_W-1:0] src_q,
    output logic [IDX_W-1:0] dst_q
);
    mode_e            mode_n;
    logic             b_n;
    logic [IDX_W-1:0] src_n;
    logic [IDX_W-1:0] dst_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_PLAIN;
            b_q    <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
        end else begin
            mode_q <= mode_n;
            b_q    <= b_n;
            src_q  <= src_n;
            dst_q  <= dst_n;
        end
    end

    always_comb begin
        mode_n = mode_q;
        b_n    = b_q;
        src_n  = src_q;
        dst_n  = dst_q;
        if (op_valid) begin
            unique case (cls)
                OC_WITH: begin
                    b_n   = 1'b1;
                    src_n = op_idx;
                    dst_n = op_idx;
                end
                OC_TO: begin
                    if (b_q) begin
                        mode_n = MD_PLAIN;
                        b_n    = 1'b0;
                        src_n  = '0;
                        dst_n  = '0;
                    end else begin
                        dst_n = op_idx;
                    end
                end
                OC_SETA1: begin
                    mode_n = mode_e'(mode_q | MD_ALT1);
                    b_n    = 1'b0;
                end
                OC_SETA2: begin
                    mode_n = mode_e'(mode_q | MD_ALT2);
                    b_n    = 1'b0;
                end
                OC_SETA3: begin
                    mode_n = MD_ALT3;
                    b_n    = 1'b0;
                end
                default: begin
                    mode_n = MD_PLAIN;
                    b_n    = 1'b0;
                    src_n  = '0;
                    dst_n  = '0;
                end
            endcase
        end
    end

    a_r2_pair_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls == OC_WITH) |=>
            (b_q && src_q == $past(op_idx) && dst_q == $past(op_idx) && $stable(mode_q)));

    a_r4_move_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls == OC_TO && b_q) |=>
            (!b_q && mode_q == MD_PLAIN && src_q == '0 && dst_q == '0));

    a_r5_alt_drops_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls inside {OC_SETA1, OC_SETA2, OC_SETA3}) |=>
            (!b_q && $stable(src_q) && $stable(dst_q) && mode_q != MD_PLAIN));

    a_r6_complete_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cls inside {OC_OTHER, OC_STORE, OC_LOAD}) |=>
            (mode_q == MD_PLAIN && !b_q && src_q == '0 && dst_q == '0));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(mode_q) && $stable(b_q) && $stable(src_q) && $stable(dst_q)));
endmodule

// File: rtl/pfx_move.sv
module pfx_move
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              op_valid,
    input  opcls_e            cls,
    input  logic              b_q,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [DATA_W-1:0] src_rdata,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              pc_step
);
    localparam logic [IDX_W-1:0] PC_IDX = '1;

    logic is_move;

    always_comb begin
        is_move = op_valid && (cls == OC_TO) && b_q;
        wr_en   = is_move;
        wr_idx  = op_idx;
        wr_data = src_rdata;
        pc_step = op_valid && !(is_move && op_idx == PC_IDX);
    end
endmodule

// File: rtl/pfx_mem_decode.sv
module pfx_mem_decode
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              op_valid,
    input  opcls_e            cls,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic              alt1,
    input  logic [DATA_W-1:0] ptr_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [IDX_W-1:0]  ptr_idx,
    output logic [DATA_W-1:0] addr_lo,
    output logic [DATA_W-1:0] addr_hi
);
    localparam logic [DATA_W-1:0] PAIR_FLIP = DATA_W'(1);

    always_comb begin
        mem_req  = op_valid && (cls == OC_STORE || cls == OC_LOAD);
        mem_we   = op_valid && (cls == OC_STORE);
        mem_byte = alt1;
        ptr_idx  = op_idx;
        addr_lo  = ptr_rdata;
        addr_hi  = ptr_rdata ^ PAIR_FLIP;
    end
endmodule

// File: rtl/pfx_select_decoder.sv
module pfx_select_decoder
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic [DATA_W-1:0] src_rdata,
    input  logic [DATA_W-1:0] ptr_rdata,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              alt1,
    output logic              alt2,
    output logic              b_flag,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              pc_step,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [IDX_W-1:0]  ptr_idx,
    output logic [DATA_W-1:0] addr_lo,
    output logic [DATA_W-1:0] addr_hi
);
    opcls_e           cls;
    mode_e            mode;
    logic [IDX_W-1:0] op_idx;

    assign op_idx = op_byte[IDX_W-1:0];

    pfx_classify u_classify (
        .op_byte (op_byte),
        .cls     (cls)
    );

    pfx_state #(.IDX_W(IDX_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .cls      (cls),
        .op_idx   (op_idx),
        .mode_q   (mode),
        .b_q      (b_flag),
        .src_q    (src_idx),
        .dst_q    (dst_idx)
    );

    assign alt1 = mode[0];
    assign alt2 = mode[1];

    pfx_move #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_move (
        .op_valid  (op_valid),
        .cls       (cls),
        .b_q       (b_flag),
        .op_idx    (op_idx),
        .src_rdata (src_rdata),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .pc_step   (pc_step)
    );

    pfx_mem_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
        .op_valid  (op_valid),
        .cls       (cls),
        .op_idx    (op_idx),
        .alt1      (alt1),
        .ptr_rdata (ptr_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_byte  (mem_byte),
        .ptr_idx   (ptr_idx),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi)
    );

    a_r9_pc_move_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '1) |-> !pc_step);

    a_r7_width_follows_alt1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_byte == alt1));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!wr_en && !mem_req && !pc_step));

    a_r4_move_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> b_flag);
endmodule

// File: tb/pfx_select_decoder_bench.sv
module pfx_select_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic [15:0] src_rdata = 16'h0000;
    logic [15:0] ptr_rdata = 16'h0000;
    logic [3:0]  src_idx, dst_idx, wr_idx, ptr_idx;
    logic        alt1, alt2, b_flag, wr_en, pc_step, mem_req, mem_we, mem_byte;
    logic [15:0] wr_data, addr_lo, addr_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfx_select_decoder u_pfx_select_decoder (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .src_rdata(src_rdata), .ptr_rdata(ptr_rdata),
        .src_idx(src_idx), .dst_idx(dst_idx), .alt1(alt1), .alt2(alt2),
        .b_flag(b_flag), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_step(pc_step), .mem_req(mem_req), .mem_we(mem_we),
        .mem_byte(mem_byte), .ptr_idx(ptr_idx), .addr_lo(addr_lo),
        .addr_hi(addr_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op, input logic [15:0] src, input logic [15:0] ptr);
        @(negedge clk);
        op_valid  = 1'b1;
        op_byte   = op;
        src_rdata = src;
        ptr_rdata = ptr;
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        op_valid = 1'b0;
        op_byte  = 8'h00;
        #1;
    endtask

    task automatic state_is(input string tag, input logic [3:0] s, input logic [3:0] d,
                            input logic a1, input logic a2, input logic b);
        chk({tag, " src"}, 32'(src_idx), 32'(s));
        chk({tag, " dst"}, 32'(dst_idx), 32'(d));
        chk({tag, " alt1"}, 32'(alt1), 32'(a1));
        chk({tag, " alt2"}, 32'(alt2), 32'(a2));
        chk({tag, " b"}, 32'(b_flag), 32'(b));
    endtask

    task automatic t_reset();
        #1;
        state_is("R1 reset", 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        chk("R1 reset wr_en", 32'(wr_en), 0);
        chk("R1 reset mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_pair();
        issue(8'h25, 16'h0, 16'h0);
        chk("R9 pair step", 32'(pc_step), 1);
        chk("R3 pair no write", 32'(wr_en), 0);
        settle();
        state_is("R2 pair", 4'd5, 4'd5, 1'b0, 1'b0, 1'b1);
        issue(8'h01, 16'h0, 16'h0);
        settle();
        state_is("R6 nop clears", 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_dest_only();
        issue(8'h17, 16'h1111, 16'h0);
        chk("R3 dest no write", 32'(wr_en), 0);
        settle();
        state_is("R3 dest", 4'd0, 4'd7, 1'b0, 1'b0, 1'b0);
        issue(8'h01, 16'h0, 16'h0);
        settle();
    endtask

    task automatic t_move();
        issue(8'h23, 16'h0, 16'h0);
        settle();
        issue(8'h1A, 16'hBEEF, 16'h0);
        chk("R4 move wr_en", 32'(wr_en), 1);
        chk("R4 move wr_idx", 32'(wr_idx), 10);
        chk("R4 move wr_data", 32'(wr_data), 32'hBEEF);
        chk("R9 move r10 step", 32'(pc_step), 1);
        settle();
        state_is("R4 after move", 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        chk("R10 idle wr_en", 32'(wr_en), 0);
    endtask

    task automatic t_move_pc();
        issue(8'h24, 16'h0, 16'h0);
        settle();
        issue(8'h1F, 16'h8000, 16'h0);
        chk("R4 move pc wr_idx", 32'(wr_idx), 15);
        chk("R4 move pc wr_data", 32'(wr_data), 32'h8000);
        chk("R9 move pc no step", 32'(pc_step), 0);
        settle();
        state_is("R4 after pc move", 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_alt_chain();
        issue(8'h26, 16'h0, 16'h0);
        settle();
        issue(8'h3D, 16'h0, 16'h0);
        settle();
        state_is("R5 set alt1", 4'd6, 4'd6, 1'b1, 1'b0, 1'b0);
        issue(8'h3E, 16'h0, 16'h0);
        settle();
        state_is("R5 chain alt2", 4'd6, 4'd6, 1'b1, 1'b1, 1'b0);
        issue(8'h13, 16'h2222, 16'h0);
        chk("R3 dest after alt no write", 32'(wr_en), 0);
        settle();
        state_is("R3 dest keeps alt", 4'd6, 4'd3, 1'b1, 1'b1, 1'b0);
        issue(8'h3C, 16'h0, 16'h0);
        chk("R7 0x3C no mem", 32'(mem_req), 0);
        settle();
        state_is("R6 0x3C clears", 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        issue(8'h3E, 16'h0, 16'h0);
        settle();
        state_is("R5 alt2 only", 4'd0, 4'd0, 1'b0, 1'b1, 1'b0);
        issue(8'h01, 16'h0, 16'h0);
        settle();
    endtask

    task automatic t_memory();
        issue(8'h34, 16'h0, 16'h1234);
        chk("R7 store req", 32'(mem_req), 1);
        chk("R7 store we", 32'(mem_we), 1);
        chk("R7 store word", 32'(mem_byte), 0);
        chk("R7 store ptr", 32'(ptr_idx), 4);
        chk("R8 store lo", 32'(addr_lo), 32'h1234);
        chk("R8 store hi", 32'(addr_hi), 32'h1235);
        settle();
        issue(8'h3F, 16'h0, 16'h0);
        settle();
        issue(8'h4B, 16'h0, 16'h0101);
        chk("R7 load req", 32'(mem_req), 1);
        chk("R7 load we", 32'(mem_we), 0);
        chk("R7 load byte alt3", 32'(mem_byte), 1);
        chk("R7 load ptr", 32'(ptr_idx), 11);
        chk("R8 load hi", 32'(addr_hi), 32'h0100);
        settle();
        state_is("R6 load clears", 4'd0, 4'd0, 1'b0, 1'b0, 1'b0);
        issue(8'h4C, 16'h0, 16'h0);
        chk("R7 0x4C no mem", 32'(mem_req), 0);
        settle();
        issue(8'h3D, 16'h0, 16'h0);
        settle();
        issue(8'h30, 16'h0, 16'h0);
        chk("R7 store byte alt1", 32'(mem_byte), 1);
        settle();
    endtask

    task automatic t_idle();
        issue(8'h29, 16'h0, 16'h0);
        settle();
        @(negedge clk);
        op_byte = 8'h01;
        #1;
        chk("R10 idle wr_en", 32'(wr_en), 0);
        chk("R10 idle mem_req", 32'(mem_req), 0);
        chk("R10 idle pc_step", 32'(pc_step), 0);
        @(negedge clk);
        #1;
        state_is("R10 idle holds", 4'd9, 4'd9, 1'b0, 1'b0, 1'b1);
        op_byte = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pair();
        t_dest_only();
        t_move();
        t_move_pc();
        t_alt_chain();
        t_memory();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule